// File: doc/BRIEF.md
# Register Window Spill/Fill Trap Detector

This block keeps the current window pointer for a register file made of overlapping register windows. In that file the outgoing registers of one window are the same physical registers as the incoming registers of the following window. Decode sends a strobe for each window-advancing instruction (`save`) and each window-retreating instruction (`restore`). The block works out the window that the instruction would move to and looks up that window's bit in an invalid-window mask. Privileged software writes this mask. If the bit is clear, the pointer moves. If the bit is set, the pointer stays where it is and the block raises a spill (overflow) or fill (underflow) trap request that carries the proposed pointer.

When a spill trap is taken, the trap entry logic elsewhere moves the pointer onto the invalid window, whose local registers are free. The handler spills the oldest window to memory, rotates the mask by one position and returns. The trapped `save` then runs again, and this time it commits. This block only decides between commit and trap. Register storage, trap entry and the handler are outside it.

Top module: `regwin_trap_ctrl`

## Requirements
- R1: After a synchronous active-high reset the pointer is 0, the mask is all zeros, both trap outputs are low and both proposed-pointer outputs are 0.
- R2: A save strobe alone, whose target window (pointer − 1 modulo the window count) has its mask bit clear, sets the pointer to the target on the same clock edge. Pointer 0 wraps to 7.
- R3: A restore strobe alone, whose target window (pointer + 1 modulo the window count) has its mask bit clear, sets the pointer to the target on the same clock edge. Pointer 7 wraps to 0.
- R4: A save strobe alone, whose target window has its mask bit set, leaves the pointer unchanged. On that edge it raises the overflow request for exactly one cycle, and the overflow proposed-pointer output equals the target.
- R5: A restore strobe alone, whose target window has its mask bit set, leaves the pointer unchanged. On that edge it raises the underflow request for exactly one cycle, and the underflow proposed-pointer output equals the target.
- R6: In a cycle after an edge that raised no trap of a given kind, that trap output is low and its proposed-pointer output is 0. The two trap outputs are never high together.
- R7: When save and restore are both high, or both low, the pointer is unchanged and no trap is raised.
- R8: A mask write appears on the mask output after its edge. A save or restore in the same cycle is judged against the old mask. Any later save or restore is judged against the new mask.
- R9: Only the target window's mask bit matters. A set bit on the current window alone does not block a move. After a spill trap, rotating the mask lets the retried save commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| save_i | input | 1 | Window-advance strobe from decode |
| restore_i | input | 1 | Window-retreat strobe from decode |
| wim_we_i | input | 1 | Privileged mask write enable |
| wim_wdata_i | input | NWIN (8) | New invalid-window mask |
| cwp_o | output | CW (3) | Current window pointer |
| wim_o | output | NWIN (8) | Current invalid-window mask |
| ovf_trap_o | output | 1 | Spill trap request, one-cycle pulse |
| ovf_cwp_o | output | CW (3) | Proposed pointer for the spill trap |
| unf_trap_o | output | 1 | Fill trap request, one-cycle pulse |
| unf_cwp_o | output | CW (3) | Proposed pointer for the fill trap |

## Verification
Directed runs of saves and restores cross both wrap points, which tells modular stepping apart from plain arithmetic. A mask bit placed on the current window and not on the target separates a correct target lookup from a lookup on the wrong index. A spill, then a rotation, then a retry covers the full recovery sequence. Mask writes issued in the same cycle as a strobe distinguish old-mask from new-mask evaluation. Random mixes of strobes, both-high collisions and mask writes then run against a bench model.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_SAVE  = 2'd1,
    OP_REST  = 2'd2,
    OP_CLASH = 2'd3
  } win_op_e;

  function automatic win_op_e decode_op(input logic sv, input logic rs);
    win_op_e op;
    case ({rs, sv})
      2'b01:   op = OP_SAVE;
      2'b10:   op = OP_REST;
      2'b11:   op = OP_CLASH;
      default: op = OP_IDLE;
    endcase
    return op;
  endfunction
endpackage

// File: rtl/regwin_step.sv
module regwin_step #(
  parameter int NWIN = 8,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [CW-1:0] cwp_i,
  output logic [CW-1:0] dn_o,
  output logic [CW-1:0] up_o
);
  localparam bit POW2 = ((1 << CW) == NWIN);

  generate
    if (POW2) begin : g_wrap
      always_comb begin
        dn_o = cwp_i - CW'(1);
        up_o = cwp_i + CW'(1);
      end
    end else begin : g_cmp
      always_comb begin
        dn_o = (cwp_i == '0) ? CW'(NWIN - 1) : cwp_i - CW'(1);
        up_o = (cwp_i == CW'(NWIN - 1)) ? '0 : cwp_i + CW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/regwin_mask.sv
module regwin_mask #(
  parameter int NWIN = 8,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [NWIN-1:0] wdata_i,
  input  logic [CW-1:0]   idx_dn_i,
  input  logic [CW-1:0]   idx_up_i,
  output logic            bad_dn_o,
  output logic            bad_up_o,
  output logic [NWIN-1:0] mask_o
);
  logic [NWIN-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)       mask_q <= '0;
    else if (we_i) mask_q <= wdata_i;
  end

  always_comb begin
    bad_dn_o = mask_q[idx_dn_i];
    bad_up_o = mask_q[idx_up_i];
  end

  assign mask_o = mask_q;

  assert_mask_write_R8: assert property (@(posedge clk) disable iff (rst)
    we_i |=> mask_o == $past(wdata_i));
  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/regwin_trap_ctrl.sv
module regwin_trap_ctrl #(
  parameter int NWIN = 8,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic            wim_we_i,
  input  logic [NWIN-1:0] wim_wdata_i,
  output logic [CW-1:0]   cwp_o,
  output logic [NWIN-1:0] wim_o,
  output logic            ovf_trap_o,
  output logic [CW-1:0]   ovf_cwp_o,
  output logic            unf_trap_o,
  output logic [CW-1:0]   unf_cwp_o
);
  import regwin_pkg::*;

  logic [CW-1:0] cwp_q, dn_w, up_w;
  logic          bad_dn_w, bad_up_w;
  win_op_e       op_w;

  regwin_step #(.NWIN(NWIN)) u_step (
    .cwp_i(cwp_q), .dn_o(dn_w), .up_o(up_w)
  );

  regwin_mask #(.NWIN(NWIN)) u_mask (
    .clk(clk), .rst(rst), .we_i(wim_we_i), .wdata_i(wim_wdata_i),
    .idx_dn_i(dn_w), .idx_up_i(up_w),
    .bad_dn_o(bad_dn_w), .bad_up_o(bad_up_w), .mask_o(wim_o)
  );

  assign op_w = decode_op(save_i, restore_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_q      <= '0;
      ovf_trap_o <= 1'b0;
      unf_trap_o <= 1'b0;
      ovf_cwp_o  <= '0;
      unf_cwp_o  <= '0;
    end else begin
      ovf_trap_o <= 1'b0;
      unf_trap_o <= 1'b0;
      ovf_cwp_o  <= '0;
      unf_cwp_o  <= '0;
      case (op_w)
        OP_SAVE: begin
          if (bad_dn_w) begin
            ovf_trap_o <= 1'b1;
            ovf_cwp_o  <= dn_w;
          end else begin
            cwp_q <= dn_w;
          end
        end
        OP_REST: begin
          if (bad_up_w) begin
            unf_trap_o <= 1'b1;
            unf_cwp_o  <= up_w;
          end else begin
            cwp_q <= up_w;
          end
        end
        default: ;
      endcase
    end
  end

  assign cwp_o = cwp_q;

  assert_save_commit_R2: assert property (@(posedge clk) disable iff (rst)
    (save_i && !restore_i && !wim_o[dn_w]) |=>
      (cwp_o == (($past(cwp_o) == '0) ? CW'(NWIN - 1) : $past(cwp_o) - CW'(1))));
  assert_restore_commit_R3: assert property (@(posedge clk) disable iff (rst)
    (restore_i && !save_i && !wim_o[up_w]) |=>
      (cwp_o == (($past(cwp_o) == CW'(NWIN - 1)) ? '0 : $past(cwp_o) + CW'(1))));
  assert_ovf_trap_R4: assert property (@(posedge clk) disable iff (rst)
    (save_i && !restore_i && wim_o[dn_w]) |=>
      (ovf_trap_o && $stable(cwp_o)));
  assert_unf_trap_R5: assert property (@(posedge clk) disable iff (rst)
    (restore_i && !save_i && wim_o[up_w]) |=>
      (unf_trap_o && $stable(cwp_o)));
  assert_traps_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(ovf_trap_o && unf_trap_o));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (save_i == restore_i) |=> ($stable(cwp_o) && !ovf_trap_o && !unf_trap_o));
endmodule

// File: tb/test_regwin_trap_ctrl.sv
module test_regwin_trap_ctrl;
  localparam int N  = 8;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          save_i, restore_i, wim_we_i;
  logic [N-1:0]  wim_wdata_i;
  logic [CW-1:0] cwp_o, ovf_cwp_o, unf_cwp_o;
  logic [N-1:0]  wim_o;
  logic          ovf_trap_o, unf_trap_o;

  int checks = 0;
  int errors = 0;

  logic [CW-1:0] m_cwp;
  logic [N-1:0]  m_wim;
  logic          m_ovf, m_unf;
  logic [CW-1:0] m_ovf_cwp, m_unf_cwp;

  always #10 clk = ~clk;

  regwin_trap_ctrl #(.NWIN(N)) i_regwin_trap_ctrl (
    .clk(clk), .rst(rst), .save_i(save_i), .restore_i(restore_i),
    .wim_we_i(wim_we_i), .wim_wdata_i(wim_wdata_i),
    .cwp_o(cwp_o), .wim_o(wim_o),
    .ovf_trap_o(ovf_trap_o), .ovf_cwp_o(ovf_cwp_o),
    .unf_trap_o(unf_trap_o), .unf_cwp_o(unf_cwp_o)
  );

  function automatic logic [CW-1:0] minus1(input logic [CW-1:0] c);
    return (c == 0) ? CW'(N - 1) : c - CW'(1);
  endfunction
  function automatic logic [CW-1:0] plus1(input logic [CW-1:0] c);
    return (c == CW'(N - 1)) ? '0 : c + CW'(1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " cwp"}, 32'(cwp_o), 32'(m_cwp));
    chk({req, " wim"}, 32'(wim_o), 32'(m_wim));
    chk({req, " ovf"}, 32'(ovf_trap_o), 32'(m_ovf));
    chk({req, " ovf_cwp"}, 32'(ovf_cwp_o), 32'(m_ovf_cwp));
    chk({req, " unf"}, 32'(unf_trap_o), 32'(m_unf));
    chk({req, " unf_cwp"}, 32'(unf_cwp_o), 32'(m_unf_cwp));
  endtask

  // Drive one cycle at the negedge, update the model, check at the next negedge.
  task automatic step(input logic s, input logic r, input logic we,
                      input logic [N-1:0] wd, input string req);
    logic [CW-1:0] t;
    save_i = s; restore_i = r; wim_we_i = we; wim_wdata_i = wd;
    m_ovf = 1'b0; m_unf = 1'b0; m_ovf_cwp = '0; m_unf_cwp = '0;
    if (s && !r) begin
      t = minus1(m_cwp);
      if (m_wim[t]) begin m_ovf = 1'b1; m_ovf_cwp = t; end
      else m_cwp = t;
    end else if (r && !s) begin
      t = plus1(m_cwp);
      if (m_wim[t]) begin m_unf = 1'b1; m_unf_cwp = t; end
      else m_cwp = t;
    end
    if (we) m_wim = wd;
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; save_i = 0; restore_i = 0; wim_we_i = 0; wim_wdata_i = '0;
    m_cwp = '0; m_wim = '0; m_ovf = 0; m_unf = 0; m_ovf_cwp = '0; m_unf_cwp = '0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst = 1'b0;

    // R2: save wraps 0 -> 7, then keeps stepping down
    step(1, 0, 0, '0, "R2 save wrap");
    chk("R2 cwp after wrap", 32'(cwp_o), 32'd7);
    step(1, 0, 0, '0, "R2 save");
    // R3: restore back across 7 -> 0
    step(0, 1, 0, '0, "R3 restore");
    step(0, 1, 0, '0, "R3 restore wrap");
    chk("R3 cwp after wrap", 32'(cwp_o), 32'd0);

    // R7: both high, and idle
    step(1, 1, 0, '0, "R7 clash");
    step(0, 0, 0, '0, "R7 idle");

    // R8: a write in the same cycle as a save: old mask (0) is used, so the save commits
    step(1, 0, 1, 8'b0100_0000, "R8 same-cycle write");
    chk("R8 committed", 32'(cwp_o), 32'd7);
    // R4: mask bit 6 is now set, so save from 7 traps
    step(1, 0, 0, '0, "R4 overflow");
    chk("R4 ovf_cwp", 32'(ovf_cwp_o), 32'd6);
    step(0, 0, 0, '0, "R6 pulse ends");
    // R9: rotate mask (bit 6 -> bit 5), retry save commits
    step(0, 0, 1, 8'b0010_0000, "R9 rotate");
    step(1, 0, 0, '0, "R9 retry");
    chk("R9 retry cwp", 32'(cwp_o), 32'd6);
    // R9: current window's bit set, target clear: restore still moves
    step(0, 0, 1, 8'b0100_0000, "R9 mark current");
    step(0, 1, 0, '0, "R9 current bit ignored");
    chk("R9 cwp", 32'(cwp_o), 32'd7);
    // R5: underflow at target 0
    step(0, 0, 1, 8'b0000_0001, "R5 setup");
    step(0, 1, 0, '0, "R5 underflow");
    chk("R5 unf_cwp", 32'(unf_cwp_o), 32'd0);
    step(1, 1, 0, '0, "R7 clash with mask");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int p;
      logic s, r, we;
      p  = int'($urandom_range(0, 9));
      s  = (p < 4) || (p == 9);
      r  = (p >= 4 && p < 8) || (p == 9);
      we = ($urandom_range(0, 5) == 0);
      step(s, r, we, N'($urandom_range(0, 255) & $urandom_range(0, 255)), "R6 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule